// File: doc/BRIEF.md
# Password-Gated Memory Access Controller

This block sits between the command decoder of a serial memory and its storage arrays. For every decoded command, it decides whether the command may go ahead. Each request carries:

- a command kind;
- a flag that says whether a password was sent;
- the 64-bit candidate password built from eight serial bytes;
- a 16-bit address;
- the level of the write-protect pin;
- the current control register byte.

The block holds four 64-bit secrets: array read, array write, one-time-area read and one-time-area write. It answers each request with an acknowledge bit, which is the result of the password poll, and a grant bit. Data may move only when the grant bit is set.

A saturating counter records every wrong password. It is never cleared by correct entries. When the eighth wrong password arrives, it raises a sticky tamper flag. The block keeps no state between requests apart from the secrets and the counter, so a denied request simply leaves the controller idle for the next one. A password command can replace one secret, but only when it presents that secret's current value. Nothing ever drives a secret onto an output.

Top module: `pwgate_ctrl`

## Requirements
- R1: Region code ctl_bits[2:0] protects addresses from 0000h up to an end address: 0 = no protection, 1 = 003Fh, 2 = 007Fh, 3 = 00FFh, 4 = 01FFh, 5 = 07FFh, 6 = 0FFFh, 7 = 1FFFh.
- R2: Array commands use req_kind 0 for read and 1 for write. Inside the protected region they are granted only as password commands. Outside it, within 0000h-1FFFh, both password and no-password commands are granted.
- R3: An array command to FFFFh targets the control register. It is granted, with resp_ctl high, only as a password command holding the array read or array write secret. A no-password command there is denied.
- R4: When wp_pin and ctl_bits[7] are both high, an array write to FFFFh is denied even when its password is correct. The acknowledge bit is still high in that case.
- R5: One-time-area commands use req_kind 2 for read and 3 for write. They are granted only as password commands with the matching secret, and only at addresses below 0080h.
- R6: resp_ack equals the password comparison result for password commands, and is 1 for no-password commands. resp_grant is never high without resp_ack.
- R7: Each password command whose password mismatches adds one to a counter that saturates at 8. Matching passwords leave the counter unchanged. tamper_flag rises on the eighth mismatch and stays high until reset.
- R8: All four secrets reset to zero. req_kind 4 with a matching current secret loads req_new_pw into the slot chosen by req_addr[1:0]: 0 array read, 1 array write, 2 one-time read, 3 one-time write. Array and one-time commands compare against slots 0-3 in kind order.
- R9: Each request produces exactly one response, with resp_valid high in the cycle after req_valid. No response appears without a request.
- R10: An array command to an address above 1FFFh other than FFFFh is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One request this cycle |
| req_kind | input | 3 | Command kind: 0 array read, 1 array write, 2 one-time read, 3 one-time write, 4 secret change |
| req_use_pw | input | 1 | Request carries a password |
| req_pw | input | 64 | Candidate password |
| req_new_pw | input | 64 | Replacement secret for kind 4 |
| req_addr | input | 16 | Target address, or slot index for kind 4 |
| wp_pin | input | 1 | Write-protect pin level |
| ctl_bits | input | 8 | Control register: bit 7 lock enable, bits 2:0 region code |
| resp_valid | output | 1 | Response present |
| resp_ack | output | 1 | Poll acknowledge |
| resp_grant | output | 1 | Access allowed |
| resp_ctl | output | 1 | Granted access targets the control register |
| tamper_flag | output | 1 | Sticky tamper indication |

## Verification
The decision is registered once, so every response bit is due at the first rising edge after the request edge. The tamper flag and any secret update land on that same edge. The driver task pushes the predicted response and drives the request on a falling edge. The monitor compares on the next falling edge, which falls after that single register stage, and only one request is in flight at a time. Because of this, a late, early or missing response shows up either as a mismatch or as a response with no queued prediction.

// File: rtl/pwgate_pkg.sv
package pwgate_pkg;

    localparam int PW_W      = 64;
    localparam int ADDR_W    = 16;
    localparam int NUM_PW    = 4;
    localparam int TAMPER_MAX = 8;

    typedef enum logic [2:0] {
        K_ARR_RD = 3'd0,
        K_ARR_WR = 3'd1,
        K_OTP_RD = 3'd2,
        K_OTP_WR = 3'd3,
        K_PW_SET = 3'd4
    } kind_e;

    typedef struct packed {
        logic ack;
        logic grant;
        logic ctl;
    } verdict_t;

    // End of the protected window for a region code; code 0 protects nothing.
    function automatic logic [ADDR_W-1:0] region_end(input logic [2:0] code);
        logic [ADDR_W-1:0] e;
        case (code)
            3'd1:    e = 16'h003F;
            3'd2:    e = 16'h007F;
            3'd3:    e = 16'h00FF;
            3'd4:    e = 16'h01FF;
            3'd5:    e = 16'h07FF;
            3'd6:    e = 16'h0FFF;
            3'd7:    e = 16'h1FFF;
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pwgate_region.sv
module pwgate_region
    import pwgate_pkg::*;
#(
    parameter int                AW        = ADDR_W,
    parameter logic [AW-1:0]     ARRAY_TOP = 16'h1FFF,
    parameter logic [AW-1:0]     CTL_ADDR  = 16'hFFFF,
    parameter int                OTP_BYTES = 64,
    parameter int                OTP_BANKS = 2
) (
    input  kind_e          kind,
    input  logic           use_pw,
    input  logic [AW-1:0]  addr,
    input  logic [2:0]     region_code,
    input  logic           wp,
    input  logic           lock_en,
    output logic           allowed,
    output logic           is_ctl
);
    localparam logic [AW-1:0] OTP_SPAN = AW'(OTP_BYTES * OTP_BANKS);

    logic arr_cmd;
    logic in_prot;

    always_comb begin
        arr_cmd = (kind == K_ARR_RD) || (kind == K_ARR_WR);
        is_ctl  = arr_cmd && (addr == CTL_ADDR);
        in_prot = (region_code != 3'd0) && (addr <= region_end(region_code));
        allowed = 1'b0;
        case (kind)
            K_ARR_RD, K_ARR_WR: begin
                if (is_ctl)
                    allowed = use_pw && !((kind == K_ARR_WR) && wp && lock_en);
                else if (addr <= ARRAY_TOP)
                    allowed = in_prot ? use_pw : 1'b1;
                else
                    allowed = 1'b0;
            end
            K_OTP_RD, K_OTP_WR: allowed = use_pw && (addr < OTP_SPAN);
            K_PW_SET:           allowed = use_pw;
            default:            allowed = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwgate_pwbank.sv
module pwgate_pwbank
    import pwgate_pkg::*;
#(
    parameter int W     = PW_W,
    parameter int SLOTS = NUM_PW,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] sel,
    input  logic [W-1:0]  cand,
    input  logic [W-1:0]  new_pw,
    input  logic          set_en,
    output logic          match
);
    logic [W-1:0] secret [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                secret[i] <= '0;
            else if (set_en && (sel == SW'(i)))
                secret[i] <= new_pw;
        end
    end

    // Full-width comparison in one cycle.
    assign match = (secret[sel] == cand);
endmodule

// File: rtl/pwgate_tamper.sv
module pwgate_tamper
    import pwgate_pkg::*;
#(
    parameter int LIMIT = TAMPER_MAX,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic bad,
    output logic flag
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (bad && (cnt != CW'(LIMIT)))
            cnt <= cnt + 1'b1;
    end

    assign flag = (cnt == CW'(LIMIT));
endmodule

// File: rtl/pwgate_ctrl.sv
module pwgate_ctrl
    import pwgate_pkg::*;
#(
    parameter int PWW = PW_W,
    parameter int AW  = ADDR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic [2:0]     req_kind,
    input  logic           req_use_pw,
    input  logic [PWW-1:0] req_pw,
    input  logic [PWW-1:0] req_new_pw,
    input  logic [AW-1:0]  req_addr,
    input  logic           wp_pin,
    input  logic [7:0]     ctl_bits,
    output logic           resp_valid,
    output logic           resp_ack,
    output logic           resp_grant,
    output logic           resp_ctl,
    output logic           tamper_flag
);
    localparam int SW = $clog2(NUM_PW);

    kind_e         kind;
    logic [SW-1:0] slot;
    logic          match, allowed, is_ctl, bad, set_en;
    verdict_t      v_now, v_q;
    logic          unused_ctl;

    assign kind       = kind_e'(req_kind);
    assign slot       = (kind == K_PW_SET) ? req_addr[SW-1:0] : req_kind[SW-1:0];
    assign unused_ctl = ^ctl_bits[6:3];

    pwgate_region #(.AW(AW)) u_region (
        .kind        (kind),
        .use_pw      (req_use_pw),
        .addr        (req_addr),
        .region_code (ctl_bits[2:0]),
        .wp          (wp_pin),
        .lock_en     (ctl_bits[7]),
        .allowed     (allowed),
        .is_ctl      (is_ctl)
    );

    pwgate_pwbank #(.W(PWW), .SLOTS(NUM_PW)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .sel    (slot),
        .cand   (req_pw),
        .new_pw (req_new_pw),
        .set_en (set_en),
        .match  (match)
    );

    assign bad    = req_valid && req_use_pw && !match;
    assign set_en = req_valid && (kind == K_PW_SET) && req_use_pw && match;

    pwgate_tamper #(.LIMIT(TAMPER_MAX)) u_tamper (
        .clk  (clk),
        .rst  (rst),
        .bad  (bad),
        .flag (tamper_flag)
    );

    always_comb begin
        v_now.ack   = req_use_pw ? match : 1'b1;
        v_now.grant = v_now.ack && allowed;
        v_now.ctl   = v_now.grant && is_ctl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            v_q        <= '0;
        end else begin
            resp_valid <= req_valid;
            v_q        <= req_valid ? v_now : '0;
        end
    end

    assign resp_ack   = v_q.ack;
    assign resp_grant = v_q.grant;
    assign resp_ctl   = v_q.ctl;
endmodule

// File: rtl/pwgate_ctrl_chk.sv
module pwgate_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [2:0]  req_kind,
    input logic        req_use_pw,
    input logic [15:0] req_addr,
    input logic        wp_pin,
    input logic [7:0]  ctl_bits,
    input logic        resp_valid,
    input logic        resp_ack,
    input logic        resp_grant,
    input logic        resp_ctl,
    input logic        tamper_flag
);
    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);  // R9
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);  // R9
    AST_GRANT_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        resp_grant |-> (resp_ack && resp_valid));  // R6
    AST_TAMPER_STICKY: assert property (@(posedge clk) disable iff (rst)
        tamper_flag |=> tamper_flag);  // R7
    AST_CTL_WRITE_LOCK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 3'd1 && req_addr == 16'hFFFF && wp_pin && ctl_bits[7])
        |=> !resp_grant);  // R4
    AST_CTL_NEEDS_PW: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_use_pw && req_kind <= 3'd1 && req_addr == 16'hFFFF)
        |=> !resp_grant);  // R3
    AST_CTL_IMPLIES_GRANT: assert property (@(posedge clk) disable iff (rst)
        resp_ctl |-> resp_grant);  // R3
    AST_OTP_NEEDS_PW: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_use_pw && (req_kind == 3'd2 || req_kind == 3'd3))
        |=> !resp_grant);  // R5
endmodule

bind pwgate_ctrl pwgate_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_use_pw  (req_use_pw),
    .req_addr    (req_addr),
    .wp_pin      (wp_pin),
    .ctl_bits    (ctl_bits),
    .resp_valid  (resp_valid),
    .resp_ack    (resp_ack),
    .resp_grant  (resp_grant),
    .resp_ctl    (resp_ctl),
    .tamper_flag (tamper_flag)
);

// File: tb/pwgate_ctrl_bench.sv
module pwgate_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic        req_use_pw = 1'b0;
    logic [63:0] req_pw = '0;
    logic [63:0] req_new_pw = '0;
    logic [15:0] req_addr = '0;
    logic        wp_pin = 1'b0;
    logic [7:0]  ctl_bits = '0;
    logic        resp_valid, resp_ack, resp_grant, resp_ctl, tamper_flag;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit    ack;
        bit    grant;
        bit    ctl;
        bit    tamp;
        string tag;
    } exp_t;
    exp_t sb[$];

    logic [63:0] shadow [4];
    int          bad_cnt = 0;

    always #2 clk = ~clk;

    pwgate_ctrl u_pwgate_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_use_pw(req_use_pw), .req_pw(req_pw), .req_new_pw(req_new_pw),
        .req_addr(req_addr), .wp_pin(wp_pin), .ctl_bits(ctl_bits),
        .resp_valid(resp_valid), .resp_ack(resp_ack), .resp_grant(resp_grant),
        .resp_ctl(resp_ctl), .tamper_flag(tamper_flag)
    );

    function automatic logic [15:0] prot_top(input logic [2:0] c);
        case (c)
            3'd1: return 16'h003F;  3'd2: return 16'h007F;
            3'd3: return 16'h00FF;  3'd4: return 16'h01FF;
            3'd5: return 16'h07FF;  3'd6: return 16'h0FFF;
            default: return 16'h1FFF;
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic send(input string tag, input int kind, input bit use_pw,
                        input logic [63:0] pw, input logic [15:0] addr,
                        input logic [63:0] npw = 64'd0);
        exp_t e;
        int   slot;
        bit   ok, match, ctl_t;
        slot  = (kind == 4) ? int'(addr[1:0]) : kind;
        match = (shadow[slot] == pw);
        e.ack = use_pw ? match : 1'b1;
        ctl_t = (kind <= 1) && (addr == 16'hFFFF);
        if (kind <= 1) begin
            if (ctl_t)
                ok = use_pw && !(kind == 1 && wp_pin && ctl_bits[7]);
            else if (addr <= 16'h1FFF)
                ok = (ctl_bits[2:0] != 0 && addr <= prot_top(ctl_bits[2:0])) ? use_pw : 1'b1;
            else
                ok = 1'b0;
        end else if (kind <= 3) ok = use_pw && (addr < 16'h0080);
        else ok = use_pw;
        e.grant = e.ack && ok;
        e.ctl   = e.grant && ctl_t;
        if (use_pw && !match && bad_cnt < 8) bad_cnt++;
        if (kind == 4 && use_pw && match) shadow[slot] = npw;
        e.tamp = (bad_cnt >= 8);
        e.tag  = tag;
        @(negedge clk);
        sb.push_back(e);
        req_valid = 1'b1; req_kind = 3'(kind); req_use_pw = use_pw;
        req_pw = pw; req_addr = addr; req_new_pw = npw;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: one registered stage, so the result is visible one falling edge later.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && resp_valid) begin
                if (sb.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R9: response with no request, actual 1 expected 0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    checks++;
                    if (resp_ack !== e.ack || resp_grant !== e.grant ||
                        resp_ctl !== e.ctl || tamper_flag !== e.tamp) begin
                        fails++;
                        $display("FAIL %s: actual ack/grant/ctl/tamp %b%b%b%b expected %b%b%b%b",
                                 e.tag, resp_ack, resp_grant, resp_ctl, tamper_flag,
                                 e.ack, e.grant, e.ctl, e.tamp);
                    end
                end
            end
        end
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset resp_valid", resp_valid, 1'b0);
        check("R7 reset tamper", tamper_flag, 1'b0);
        check("R6 reset grant", resp_grant, 1'b0);

        ctl_bits = 8'h00;
        send("R1 code0 nopw read", 0, 0, 0, 16'h0100);
        ctl_bits = 8'h01;
        send("R1 code1 top edge", 0, 0, 0, 16'h003F);
        send("R1 code1 above edge", 0, 0, 0, 16'h0040);
        ctl_bits = 8'h03;
        send("R1 code3 top edge", 1, 0, 0, 16'h00FF);
        send("R2 code3 outside", 1, 0, 0, 16'h0100);
        ctl_bits = 8'h07;
        send("R2 whole array nopw", 1, 0, 0, 16'h1FFF);
        send("R8 zero secret write", 1, 1, 0, 16'h1FFF);
        send("R2 pw cmd outside", 0, 1, 0, 16'h0000);

        send("R3 ctl read pw", 0, 1, 0, 16'hFFFF);
        send("R3 ctl read nopw", 0, 0, 0, 16'hFFFF);
        wp_pin = 1'b1; ctl_bits = 8'h87;
        send("R4 locked ctl write", 1, 1, 0, 16'hFFFF);
        wp_pin = 1'b0;
        send("R4 unlocked ctl write", 1, 1, 0, 16'hFFFF);
        wp_pin = 1'b1; ctl_bits = 8'h07;
        send("R4 lock bit low", 1, 1, 0, 16'hFFFF);
        wp_pin = 1'b0;

        send("R5 otp read last", 2, 1, 0, 16'h007F);
        send("R5 otp beyond", 3, 1, 0, 16'h0080);
        send("R5 otp nopw", 2, 0, 0, 16'h0010);
        send("R10 beyond array", 0, 0, 0, 16'h2000);

        send("R8 change wr secret", 4, 1, 0, 16'h0001, 64'hA5A5_0000_FFFF_1234);
        send("R6 old secret rejected", 1, 1, 0, 16'h0000);
        send("R8 new secret accepted", 1, 1, 64'hA5A5_0000_FFFF_1234, 16'h0000);
        send("R8 read slot unchanged", 0, 1, 0, 16'h0000);
        send("R6 one bit off", 1, 1, 64'hA5A5_0000_FFFF_1235, 16'h0000);
        send("R8 bad change refused", 4, 1, 64'h1, 16'h0002, 64'h55);
        send("R5 otp rd secret kept", 2, 1, 0, 16'h0000);

        // bad_cnt is 3 here; interleave good entries up to the eighth bad one.
        for (int i = 0; i < 4; i++) begin
            send("R7 bad entry", 0, 1, 64'hDEAD, 16'h0000);
            send("R7 good between", 0, 1, 0, 16'h0000);
        end
        check("R7 flag low at seven", tamper_flag, 1'b0);
        send("R7 eighth bad", 3, 1, 64'hBEEF, 16'h0000);
        send("R7 good after", 0, 1, 0, 16'h0000);
        send("R7 more bad", 0, 1, 64'h1, 16'h0000);
        repeat (3) @(negedge clk);
        check("R7 flag held", tamper_flag, 1'b1);
        check("R9 queue drained", sb.size() == 0, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule